// File: doc/BRIEF.md
# Per-Channel Acquisition Timing Controller

This block belongs to an automatic ADC channel sequencer. When the sequencer begins the sample-and-hold phase for a channel, it presents the channel index and a one-cycle start strobe. The controller then counts the acquisition phase on the ADC clock and raises a one-cycle done strobe when the phase is over. Alongside the done strobe it gives a flag that tells the converter whether to use bipolar or unipolar coding for that conversion.

Two 64-bit masks set the behaviour of each channel. Each mask is a pair of 32-bit words, with the upper word in bits [63:32]. Bit k of a mask belongs to channel index k. The extend mask picks a long acquisition. The mode mask picks bipolar coding. Only the external inputs obey the masks: the dedicated input pair and the sixteen auxiliary pairs. Every other index is an internal sensor, which always gets the short acquisition and unipolar coding.

A new start strobe that arrives during a count abandons that count and begins a fresh one for the newly supplied channel.

Top module: `acq_timing_ctrl`

## Requirements
- R1: For an external channel whose extend bit is 0, `acq_done` is high in the cycle after the 4th rising edge that follows the edge sampling `acq_start`.
- R2: For an external channel whose extend bit is 1, `acq_done` is high in the cycle after the 10th rising edge that follows the start edge.
- R3: For an external channel, `bipolar` becomes the channel's mode-mask bit (1 = bipolar, 0 = unipolar) in the cycle after the start edge.
- R4: For an internal channel, `bipolar` is 0 and the acquisition lasts 4 cycles, whatever either mask holds.
- R5: Mask bit k belongs to channel index k. The dedicated pair is index 11, which is bit 11 of the lower word. Auxiliary pair n (0 to 15) is index 32+n, which is bit n of the upper word. All other indices are internal.
- R6: `acq_done` is high for exactly one cycle per completed acquisition, and it is never high without a preceding start.
- R7: A start strobe during an acquisition reloads the count for the new channel. No done pulse is given for the abandoned count, and this also holds when the restart falls on the edge where the old count would have ended.
- R8: `bipolar`, the acquisition length and the choice of channel are latched at the start edge. Changes to the masks or to the channel index after that edge have no effect until the next start.
- R9: A synchronous active-high `rst` clears `acq_done` and `bipolar` to 0 and abandons any count in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | ADC clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_start | input | 1 | One-cycle strobe that begins an acquisition |
| chan_sel | input | 6 | Channel index, equal to its bit position in the masks |
| ext_mask | input | 64 | Acquisition-extend mask, upper word in [63:32] |
| mode_mask | input | 64 | Input-mode mask (1 = bipolar), upper word in [63:32] |
| acq_done | output | 1 | One-cycle strobe at the end of acquisition |
| bipolar | output | 1 | Coding for the current conversion (1 = bipolar) |

## Verification
Directed starts on the dedicated pair and on auxiliary pair 1 are run with each extend and mode setting. These show the 4-cycle and 10-cycle lengths apart and confirm which word and bit each channel reads. Internal indices are started with both masks all ones, which separates forced behaviour from behaviour set by the masks. Restarts are placed mid-count and on the expiry edge, and the masks and channel index are toggled during a count; these runs separate the reload-and-latch behaviour from a design that samples its inputs live. Random channels, masks and strobe densities then mix back-to-back, overlapping and isolated acquisitions.

// File: rtl/acq_timing_pkg.sv
package acq_timing_pkg;

  localparam int unsigned WORD_W_DEF   = 32;
  localparam int unsigned DED_IDX_DEF  = 11;
  localparam int unsigned AUX_BASE_DEF = 32;
  localparam int unsigned AUX_CNT_DEF  = 16;
  localparam int unsigned SHORT_DEF    = 4;
  localparam int unsigned LONG_DEF     = 10;

  // True when a mask position belongs to an external analog input.
  function automatic bit chan_is_external(input int unsigned idx,
                                          input int unsigned ded_idx,
                                          input int unsigned aux_base,
                                          input int unsigned aux_cnt);
    return (idx == ded_idx) || ((idx >= aux_base) && (idx < aux_base + aux_cnt));
  endfunction

endpackage

// File: rtl/acq_chan_decode.sv
module acq_chan_decode
  import acq_timing_pkg::*;
#(
  parameter int unsigned MASK_W   = 64,
  parameter int unsigned SEL_W    = 6,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned DED_IDX  = DED_IDX_DEF,
  parameter int unsigned AUX_BASE = AUX_BASE_DEF,
  parameter int unsigned AUX_CNT  = AUX_CNT_DEF,
  parameter int unsigned SHORT    = SHORT_DEF,
  parameter int unsigned LONG     = LONG_DEF
) (
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic [MASK_W-1:0] ext_mask,
  input  logic [MASK_W-1:0] mode_mask,
  output logic              is_ext,
  output logic              use_bip,
  output logic [CNT_W-1:0]  acq_len
);

  localparam logic [CNT_W-1:0] SHORT_L = CNT_W'(SHORT);
  localparam logic [CNT_W-1:0] LONG_L  = CNT_W'(LONG);

  // Fixed map of positions that belong to external inputs.
  logic [MASK_W-1:0] ext_valid;

  for (genvar i = 0; i < MASK_W; i++) begin : g_valid
    assign ext_valid[i] = chan_is_external(i, DED_IDX, AUX_BASE, AUX_CNT);
  end

  always_comb begin
    is_ext  = ext_valid[chan_sel];
    use_bip = is_ext & mode_mask[chan_sel];
    acq_len = (is_ext & ext_mask[chan_sel]) ? LONG_L : SHORT_L;
  end

endmodule

// File: rtl/acq_counter.sv
module acq_counter #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned LONG  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (load) begin
      remain <= len - CNT_W'(1);
      busy   <= 1'b1;
      done   <= 1'b0;
    end else if (busy) begin
      if (remain == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        remain <= remain - CNT_W'(1);
        done   <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy)); // R6

  AST_RESTART_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    load |=> (!done && busy)); // R7

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (remain < CNT_W'(LONG))); // R2

endmodule

// File: rtl/acq_timing_ctrl.sv
module acq_timing_ctrl
  import acq_timing_pkg::*;
#(
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned DED_IDX  = DED_IDX_DEF,
  parameter int unsigned AUX_BASE = AUX_BASE_DEF,
  parameter int unsigned AUX_CNT  = AUX_CNT_DEF,
  parameter int unsigned SHORT    = SHORT_DEF,
  parameter int unsigned LONG     = LONG_DEF,
  localparam int unsigned MASK_W  = 2 * WORD_W,
  localparam int unsigned SEL_W   = $clog2(MASK_W),
  localparam int unsigned CNT_W   = $clog2(LONG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq_start,
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic [MASK_W-1:0] ext_mask,
  input  logic [MASK_W-1:0] mode_mask,
  output logic              acq_done,
  output logic              bipolar
);

  logic             is_ext;
  logic             use_bip;
  logic [CNT_W-1:0] acq_len;
  logic             busy;

  acq_chan_decode #(
    .MASK_W(MASK_W), .SEL_W(SEL_W), .CNT_W(CNT_W),
    .DED_IDX(DED_IDX), .AUX_BASE(AUX_BASE), .AUX_CNT(AUX_CNT),
    .SHORT(SHORT), .LONG(LONG)
  ) u_decode (
    .chan_sel (chan_sel),
    .ext_mask (ext_mask),
    .mode_mask(mode_mask),
    .is_ext   (is_ext),
    .use_bip  (use_bip),
    .acq_len  (acq_len)
  );

  acq_counter #(.CNT_W(CNT_W), .LONG(LONG)) u_count (
    .clk (clk),
    .rst (rst),
    .load(acq_start),
    .len (acq_len),
    .busy(busy),
    .done(acq_done)
  );

  always_ff @(posedge clk) begin
    if (rst)            bipolar <= 1'b0;
    else if (acq_start) bipolar <= use_bip;
  end

  AST_BIPOLAR_HELD: assert property (@(posedge clk) disable iff (rst)
    !acq_start |=> $stable(bipolar)); // R8

  AST_INTERNAL_UNIPOLAR: assert property (@(posedge clk) disable iff (rst)
    (acq_start && !is_ext) |=> !bipolar); // R4

  AST_INTERNAL_SHORT: assert property (@(posedge clk) disable iff (rst)
    (acq_start && !is_ext) |-> (acq_len == CNT_W'(SHORT))); // R4

  AST_BIPOLAR_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (rst)
    (acq_start && is_ext) |=> (bipolar == $past(mode_mask[chan_sel]))); // R3

endmodule

// File: tb/acq_timing_ctrl_test.sv
`timescale 1ns/1ps
module acq_timing_ctrl_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        acq_start;
  logic [5:0]  chan_sel;
  logic [63:0] ext_mask;
  logic [63:0] mode_mask;
  logic        acq_done;
  logic        bipolar;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R9";

  // Reference model state.
  int remain  = 0;
  bit exp_done = 0;
  bit exp_bip  = 0;

  always #10 clk = ~clk;

  acq_timing_ctrl uut (
    .clk(clk), .rst(rst), .acq_start(acq_start), .chan_sel(chan_sel),
    .ext_mask(ext_mask), .mode_mask(mode_mask),
    .acq_done(acq_done), .bipolar(bipolar)
  );

  // Which index positions are external inputs.
  function automatic bit ref_external(input int ch);
    return (ch == 11) || (ch >= 32 && ch <= 47);
  endfunction

  function automatic int ref_len(input int ch, input logic [63:0] em);
    return (ref_external(ch) && em[ch]) ? 10 : 4;
  endfunction

  function automatic bit ref_bip(input int ch, input logic [63:0] mm);
    return ref_external(ch) && mm[ch];
  endfunction

  task automatic check_outputs();
    checks++;
    if (acq_done !== exp_done || bipolar !== exp_bip) begin
      errors++;
      $display("FAIL %s cycle %0d: done=%0b bipolar=%0b expected done=%0b bipolar=%0b",
               tag, cycles, acq_done, bipolar, exp_done, exp_bip);
    end
  endtask

  // One clock: check at negedge, apply inputs, update model for the next edge.
  task automatic step(input bit r, input bit s, input int ch,
                      input logic [63:0] em, input logic [63:0] mm);
    rst = r; acq_start = s; chan_sel = 6'(ch); ext_mask = em; mode_mask = mm;
    if (r) begin
      remain = 0; exp_done = 0; exp_bip = 0;
    end else if (s) begin
      remain = ref_len(ch, em); exp_done = 0; exp_bip = ref_bip(ch, mm);
    end else if (remain > 0) begin
      remain--; exp_done = (remain == 0);
    end else begin
      exp_done = 0;
    end
    @(negedge clk);
    cycles++;
    check_outputs();
  endtask

  task automatic idle(input int n, input logic [63:0] em, input logic [63:0] mm);
    for (int i = 0; i < n; i++) step(0, 0, 0, em, mm);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [63:0] ones = '1;
    void'($urandom(32'd1234));
    rst = 1; acq_start = 0; chan_sel = 0; ext_mask = 0; mode_mask = 0;
    @(negedge clk);
    tag = "R9";
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    idle(3, 0, 0);

    tag = "R1";                                  // dedicated pair, short
    step(0, 1, 11, 0, 0);             idle(7, 0, 0);
    tag = "R2";                                  // dedicated pair, long, bipolar
    step(0, 1, 11, 64'h800, 64'h800); idle(12, 0, 0);
    tag = "R3";                                  // aux pair 5 bipolar, then unipolar
    step(0, 1, 37, 0, 64'h20 << 32);  idle(6, 0, 0);
    step(0, 1, 37, 0, 0);             idle(6, 0, 0);
    tag = "R5";                                  // aux pair 1 = upper bit 1; lower bit 1 is internal
    step(0, 1, 33, 64'h2 << 32, 64'h2 << 32); idle(12, 0, 0);
    step(0, 1, 1, 64'h2, 64'h2);      idle(6, 0, 0);
    step(0, 1, 48, ones, ones);       idle(6, 0, 0);
    tag = "R4";                                  // internal indices ignore full masks
    step(0, 1, 0, ones, ones);        idle(6, ones, ones);
    step(0, 1, 63, ones, ones);       idle(6, ones, ones);
    tag = "R7";                                  // restart mid-count and on expiry edge
    step(0, 1, 40, ones, 0);          idle(5, 0, 0);
    step(0, 1, 11, 0, ones);          idle(3, 0, 0);
    step(0, 1, 40, ones, 0);          idle(12, 0, 0);
    tag = "R8";                                  // inputs change during count
    step(0, 1, 45, 0, 64'h2000 << 32);
    for (int i = 0; i < 6; i++) step(0, 0, i * 9, ones, ~64'(1) << 0);
    tag = "R6";
    idle(4, 0, 0);
    tag = "R9";                                  // reset aborts a count
    step(0, 1, 11, ones, ones);       idle(2, 0, 0);
    step(1, 0, 0, 0, 0);              idle(12, 0, 0);

    tag = "R6";                                  // random mix
    for (int i = 0; i < 6000; i++) begin
      int density = (i < 3000) ? 12 : 3;
      bit s = ($urandom % density) == 0;
      int ch = ($urandom % 4 == 0) ? (32 + $urandom % 16) : ($urandom % 64);
      step(0, s, ch, {$urandom, $urandom}, {$urandom, $urandom});
    end
    idle(12, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule